// File: doc/BRIEF.md
# Dual-Slope Conversion Sequencer

This block is the digital controller of an integrating analog-to-digital converter. When a conversion starts, it closes the input switch so that an external integrator charges from the measured signal for a fixed number of clocks. It then opens that switch and samples the comparator to learn which side of baseline the integrator ended on. Next it closes the reference switch of the opposite polarity and counts clocks until the comparator reports that the charge is back at baseline. The count at that moment is the signed reading.

Conversions are paced by a slow external timebase tick, and a two-bit mode input selects the rate. Fast mode starts a conversion every `FAST_TICKS` ticks, and slow mode every `SLOW_TICKS` ticks. In hold mode, conversions keep running at the slow rate, but the published reading stays frozen. Once hold has been used, the block stays at the slow rate until reset. Readings that run too long are reported as positive or negative overrange. A one-cycle strobe marks each new published reading.

Top module: `dual_slope_seq`

## Requirements
- R1: After a start, `sw_int` is high for exactly `INT_CYCLES` consecutive clocks. The sign is taken from `cmp_hi` on the last of those clocks: 1 means positive.
- R2: During de-integration, exactly one reference strobe is high. `sw_ref_neg` is used for a positive sign and `sw_ref_pos` for a negative one. No switch strobe is high while the block is idle.
- R3: The reading's magnitude is the number of de-integration clocks that elapse before `cmp_hi` first differs from the latched sign. `result` is two's complement and is negative for a negative sign.
- R4: If a positive conversion has not tripped after `POS_LIMIT` (1000) de-integration clocks, the published reading is 0 with `ovr_pos`=1. A positive reading of 999 is still valid.
- R5: If a negative conversion has not tripped by its de-integration clock with index `NEG_LIMIT` (99), the reading is 0 with `ovr_neg`=1. Negative readings down to -99 are valid.
- R6: `mode_sel` is sampled only when a conversion starts. The encodings are 2'b00 slow, 2'b01 fast, 2'b10 hold, and 2'b11 slow. The next start follows the previous start by exactly P ticks, where P is the period of the mode latched at that previous start, as long as the conversion finished in time.
- R7: A conversion started in hold mode uses the slow period. It changes none of `result`, `ovr_pos` or `ovr_neg`, and produces no `result_valid`.
- R8: Once any conversion has started in hold, later fast-mode conversions use the slow period until reset. Conversions in slow or fast mode after hold publish normally again.
- R9: `result_valid` is high for exactly one clock per published reading. That clock is the one in which the new value first appears.
- R10: While in reset and just after it, all switch strobes, `result`, both overrange flags and `result_valid` are 0.
- R11: Conversions never overlap. If a conversion is still running when its period expires, the next start occurs on the first tick after it ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-clock pulse from the pacing timebase |
| mode_sel | input | 2 | 00 slow, 01 fast, 10 hold, 11 slow |
| cmp_hi | input | 1 | Comparator: integrator above baseline |
| sw_int | output | 1 | Connect input to integrator |
| sw_ref_pos | output | 1 | Apply positive reference (negative reading) |
| sw_ref_neg | output | 1 | Apply negative reference (positive reading) |
| result | output | $clog2(POS_LIMIT)+1 | Signed published reading |
| ovr_pos | output | 1 | Published reading is a positive overrange |
| ovr_neg | output | 1 | Published reading is a negative overrange |
| result_valid | output | 1 | One-clock strobe on each publish |

## Verification
The hardest situation to reach from the ports is the interaction between pacing and conversion length. The exact start-to-start interval can only be seen when the conversion ends before its period does. A fast period that expires during a long positive conversion must instead defer the next start to the first tick after the end. The bench models the integrator as a comparator that flips after a chosen number of reference clocks, so the conversion length is set directly by the input value. It then mixes short readings, full-scale and overrange values with fast, slow, hold and post-hold modes. For each start it predicts either the exact interval or the deferred bound.

// File: rtl/dsq_pkg.sv
package dsq_pkg;
  typedef enum logic [1:0] {
    MODE_SLOW = 2'b00,
    MODE_FAST = 2'b01,
    MODE_HOLD = 2'b10
  } mode_e;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'b00,
    PH_INTEG = 2'b01,
    PH_DEINT = 2'b10
  } phase_e;
endpackage

// File: rtl/dsq_pacer.sv
module dsq_pacer
  import dsq_pkg::*;
#(
  parameter int FAST_TICKS = 8,
  parameter int SLOW_TICKS = 196
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       idle,
  input  logic [1:0] mode_in,
  output logic       start,
  output logic       hold_conv
);
  localparam int PW = $clog2(SLOW_TICKS + 1);
  localparam logic [PW-1:0] FAST_M1 = PW'(FAST_TICKS - 1);
  localparam logic [PW-1:0] SLOW_M1 = PW'(SLOW_TICKS - 1);

  logic [PW-1:0] pace_q, pace_d;
  logic          fast_q, fast_d;
  logic          lock_q, lock_d;
  logic          hold_q, hold_d;
  logic [PW-1:0] limit;

  always_comb begin
    limit  = fast_q ? FAST_M1 : SLOW_M1;
    start  = tick && idle && (pace_q >= limit);
    pace_d = pace_q;
    fast_d = fast_q;
    lock_d = lock_q;
    hold_d = hold_q;
    if (start) begin
      pace_d = '0;
      hold_d = (mode_in == MODE_HOLD);
      fast_d = (mode_in == MODE_FAST) && !lock_q;
      lock_d = lock_q || (mode_in == MODE_HOLD);
    end else if (tick && (pace_q < SLOW_M1)) begin
      pace_d = pace_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pace_q <= '0;
      fast_q <= 1'b0;
      lock_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      pace_q <= pace_d;
      fast_q <= fast_d;
      lock_q <= lock_d;
      hold_q <= hold_d;
    end
  end

  assign hold_conv = hold_q;

  // R8
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(lock_q) |-> lock_q);

  // R8
  lock_forces_slow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |-> !fast_q);

  // R7
  hold_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_q |-> !fast_q);
endmodule

// File: rtl/dsq_phase.sv
module dsq_phase
  import dsq_pkg::*;
#(
  parameter int INT_CYCLES = 1000,
  parameter int POS_LIMIT  = 1000,
  parameter int NEG_LIMIT  = 99,
  parameter int RW         = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          cmp_hi,
  output phase_e        phase,
  output logic          sign_pos,
  output logic          done,
  output logic [RW-1:0] done_val,
  output logic          done_ovp,
  output logic          done_ovn
);
  localparam int CMAX = (INT_CYCLES > POS_LIMIT) ? INT_CYCLES : POS_LIMIT;
  localparam int CW   = $clog2(CMAX + 1);
  localparam logic [CW-1:0] INT_M1   = CW'(INT_CYCLES - 1);
  localparam logic [CW-1:0] POS_M1   = CW'(POS_LIMIT - 1);
  localparam logic [CW-1:0] NEG_LAST = CW'(NEG_LIMIT);

  phase_e        ph_q, ph_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          pos_q, pos_d;
  logic [RW-1:0] mag;

  always_comb begin
    ph_d     = ph_q;
    cnt_d    = cnt_q;
    pos_d    = pos_q;
    done     = 1'b0;
    done_ovp = 1'b0;
    done_ovn = 1'b0;
    done_val = '0;
    mag      = RW'(cnt_q);
    case (ph_q)
      PH_IDLE: begin
        if (start) begin
          ph_d  = PH_INTEG;
          cnt_d = '0;
        end
      end
      PH_INTEG: begin
        if (cnt_q == INT_M1) begin
          ph_d  = PH_DEINT;
          cnt_d = '0;
          pos_d = cmp_hi;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      PH_DEINT: begin
        if (cmp_hi != pos_q) begin
          ph_d     = PH_IDLE;
          done     = 1'b1;
          done_val = pos_q ? mag : (~mag + 1'b1);
        end else if (pos_q && (cnt_q == POS_M1)) begin
          ph_d     = PH_IDLE;
          done     = 1'b1;
          done_ovp = 1'b1;
        end else if (!pos_q && (cnt_q == NEG_LAST)) begin
          ph_d     = PH_IDLE;
          done     = 1'b1;
          done_ovn = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
      pos_q <= 1'b0;
    end else begin
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
      pos_q <= pos_d;
    end
  end

  assign phase    = ph_q;
  assign sign_pos = pos_q;

  // R1
  int_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ph_q == PH_INTEG) |-> $past(cnt_q) == INT_M1);

  // R4
  pos_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_DEINT) |-> cnt_q <= POS_M1);

  // R5
  neg_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_DEINT && !pos_q) |-> cnt_q <= NEG_LAST);
endmodule

// File: rtl/dsq_publish.sv
module dsq_publish #(
  parameter int RW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          done,
  input  logic          hold_conv,
  input  logic [RW-1:0] done_val,
  input  logic          done_ovp,
  input  logic          done_ovn,
  output logic [RW-1:0] res,
  output logic          ovp,
  output logic          ovn,
  output logic          valid
);
  logic [RW-1:0] res_q;
  logic          ovp_q, ovn_q, valid_q;
  logic          upd_en;

  assign upd_en = done && !hold_conv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q   <= '0;
      ovp_q   <= 1'b0;
      ovn_q   <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= upd_en;
      if (upd_en) begin
        res_q <= done_val;
        ovp_q <= done_ovp;
        ovn_q <= done_ovn;
      end
    end
  end

  assign res   = res_q;
  assign ovp   = ovp_q;
  assign ovn   = ovn_q;
  assign valid = valid_q;

  // R9
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |=> !valid_q);

  // R7
  hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && hold_conv) |=> ($stable(res_q) && $stable(ovp_q) && !valid_q));

  // R4
  ovr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovp_q || ovn_q) |-> (res_q == '0) && !(ovp_q && ovn_q));
endmodule

// File: rtl/dual_slope_seq.sv
module dual_slope_seq
  import dsq_pkg::*;
#(
  parameter int INT_CYCLES = 1000,
  parameter int POS_LIMIT  = 1000,
  parameter int NEG_LIMIT  = 99,
  parameter int FAST_TICKS = 8,
  parameter int SLOW_TICKS = 196,
  localparam int RW = $clog2(POS_LIMIT) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic [1:0]    mode_sel,
  input  logic          cmp_hi,
  output logic          sw_int,
  output logic          sw_ref_pos,
  output logic          sw_ref_neg,
  output logic [RW-1:0] result,
  output logic          ovr_pos,
  output logic          ovr_neg,
  output logic          result_valid
);
  logic          rst_m, rst_s;
  phase_e        phase;
  logic          sign_pos, start, hold_conv, done, done_ovp, done_ovn;
  logic [RW-1:0] done_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m <= 1'b0;
      rst_s <= 1'b0;
    end else begin
      rst_m <= 1'b1;
      rst_s <= rst_m;
    end
  end

  dsq_pacer #(.FAST_TICKS(FAST_TICKS), .SLOW_TICKS(SLOW_TICKS)) pacer_i (
    .clk(clk), .rst_n(rst_s), .tick(tick), .idle(phase == PH_IDLE),
    .mode_in(mode_sel), .start(start), .hold_conv(hold_conv));

  dsq_phase #(.INT_CYCLES(INT_CYCLES), .POS_LIMIT(POS_LIMIT),
              .NEG_LIMIT(NEG_LIMIT), .RW(RW)) phase_i (
    .clk(clk), .rst_n(rst_s), .start(start), .cmp_hi(cmp_hi),
    .phase(phase), .sign_pos(sign_pos), .done(done), .done_val(done_val),
    .done_ovp(done_ovp), .done_ovn(done_ovn));

  dsq_publish #(.RW(RW)) publish_i (
    .clk(clk), .rst_n(rst_s), .done(done), .hold_conv(hold_conv),
    .done_val(done_val), .done_ovp(done_ovp), .done_ovn(done_ovn),
    .res(result), .ovp(ovr_pos), .ovn(ovr_neg), .valid(result_valid));

  assign sw_int     = (phase == PH_INTEG);
  assign sw_ref_neg = (phase == PH_DEINT) && sign_pos;
  assign sw_ref_pos = (phase == PH_DEINT) && !sign_pos;

  // R2
  sw_onehot_chk: assert property (@(posedge clk) disable iff (!rst_s)
    $onehot0({sw_int, sw_ref_pos, sw_ref_neg}));

  // R11
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (sw_ref_pos || sw_ref_neg) |=> !sw_int);
endmodule

// File: tb/dual_slope_seq_tb_top.sv
module dual_slope_seq_tb_top;
  localparam int INT_C = 16;
  localparam int FAST  = 4;
  localparam int SLOW  = 12;
  localparam int TD    = 40;
  localparam int RW    = 11;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick = 1'b0;
  logic [1:0]    mode_sel = 2'b00;
  logic          cmp_hi = 1'b0;
  logic          sw_int, sw_ref_pos, sw_ref_neg;
  logic [RW-1:0] result;
  logic          ovr_pos, ovr_neg, result_valid;

  dual_slope_seq #(.INT_CYCLES(INT_C), .FAST_TICKS(FAST), .SLOW_TICKS(SLOW)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .mode_sel(mode_sel), .cmp_hi(cmp_hi),
    .sw_int(sw_int), .sw_ref_pos(sw_ref_pos), .sw_ref_neg(sw_ref_neg),
    .result(result), .ovr_pos(ovr_pos), .ovr_neg(ovr_neg),
    .result_valid(result_valid));

  always #5 clk = ~clk;

  int n_chk = 0, n_fail = 0, cyc = 0, tdiv = 0;
  int v_mag = 0, k = 0, int_len = 0, vcount = 0;
  bit v_pos = 1'b1, seen_pos = 0, seen_neg = 0, finished = 0;
  int exp_res = 0; bit exp_ovp = 0, exp_ovn = 0;
  bit b_lock = 0, have_prev = 0;
  int prev_start = 0, prev_end = 0, prev_period = SLOW;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    tdiv = (tdiv == TD - 1) ? 0 : tdiv + 1;
    tick = (tdiv == 0);
    if (rst_n) begin
      if (sw_int) begin
        int_len++; k = 0; cmp_hi = v_pos;
      end else if (sw_ref_pos || sw_ref_neg) begin
        cmp_hi = (k >= v_mag) ? !v_pos : v_pos;
        k++;
        if (sw_ref_neg) seen_neg = 1; else seen_pos = 1;
      end
      if (result_valid) vcount++;
    end
  end

  task automatic chk(bit ok, string req, string what, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  function automatic int period_of(int m, bit lock);
    return (m == 1 && !lock) ? FAST : SLOW;
  endfunction

  task automatic run_conv(int v, int m);
    int st, en, vc0;
    bit hold;
    hold = (m == 2);
    v_pos = (v >= 0);
    v_mag = (v >= 0) ? v : -v;
    mode_sel = 2'(m);
    int_len = 0; seen_pos = 0; seen_neg = 0;
    vc0 = vcount;
    do begin @(negedge clk); #1; end while (!sw_int);
    st = cyc;
    if (have_prev) begin
      if (prev_end - prev_start < prev_period * TD)
        // R6 R8: exact interval from the previous start
        chk(st - prev_start == prev_period * TD, "R6", "start interval",
            st - prev_start, prev_period * TD);
      else
        // R11: deferred start within one tick of the end
        chk(st - prev_end >= 1 && st - prev_end <= TD, "R11", "deferred start gap",
            st - prev_end, TD);
    end
    do begin @(negedge clk); #1; end while (sw_int || sw_ref_pos || sw_ref_neg);
    en = cyc;
    chk(int_len == INT_C, "R1", "integration length", int_len, INT_C);
    // R2: reference opposite to sign
    chk(seen_neg == v_pos && seen_pos == !v_pos, "R2", "reference polarity",
        {30'd0, seen_neg, seen_pos}, v_pos ? 2 : 1);
    if (!hold) begin
      if (v >= 0 && v <= 999) begin exp_res = v; exp_ovp = 0; exp_ovn = 0; end
      else if (v < 0 && v >= -99) begin exp_res = v; exp_ovp = 0; exp_ovn = 0; end
      else if (v > 999) begin exp_res = 0; exp_ovp = 1; exp_ovn = 0; end
      else begin exp_res = 0; exp_ovp = 0; exp_ovn = 1; end
    end
    chk(int'($signed(result)) == exp_res, hold ? "R7" : "R3", "result",
        int'($signed(result)), exp_res);
    chk(ovr_pos == exp_ovp, hold ? "R7" : "R4", "ovr_pos", ovr_pos, exp_ovp);
    chk(ovr_neg == exp_ovn, hold ? "R7" : "R5", "ovr_neg", ovr_neg, exp_ovn);
    chk(result_valid == !hold, "R9", "valid with new value", result_valid, !hold);
    @(negedge clk); @(negedge clk); #1;
    chk(vcount - vc0 == (hold ? 0 : 1), hold ? "R7" : "R9", "valid pulse count",
        vcount - vc0, hold ? 0 : 1);
    prev_period = period_of(m, b_lock);
    b_lock = b_lock || hold;
    prev_start = st; prev_end = en; have_prev = 1;
  endtask

  always @(negedge clk) begin
    if (cyc > 190000 && !finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 190000);
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    repeat (4) @(negedge clk);
    #1;
    // R10: reset state
    chk({sw_int, sw_ref_pos, sw_ref_neg} == 3'b000, "R10", "switches in reset",
        {sw_int, sw_ref_pos, sw_ref_neg}, 0);
    chk(result == '0 && !ovr_pos && !ovr_neg && !result_valid, "R10", "outputs in reset",
        result, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    #1;
    chk(!sw_int && !result_valid && result == '0, "R10", "outputs after reset", result, 0);

    // fast mode, boundaries (R3 R4 R5)
    run_conv(5, 1);
    run_conv(0, 1);
    run_conv(-1, 1);
    run_conv(-99, 1);
    run_conv(-100, 1);
    run_conv(999, 1);
    run_conv(1000, 1);
    run_conv(-150, 1);
    run_conv(64, 1);
    // slow and code 11 (R6)
    run_conv(37, 0);
    run_conv(-42, 3);
    run_conv(250, 0);
    run_conv(8, 0);
    // hold (R7)
    run_conv(500, 2);
    run_conv(-7, 2);
    // release (R8)
    run_conv(12, 0);
    run_conv(33, 1);
    run_conv(-20, 1);
    run_conv(90, 1);

    for (int i = 0; i < 24; i++) begin
      int sel, v, m;
      sel = int'($urandom_range(0, 9));
      if (sel < 5) v = int'($urandom_range(0, 300));
      else if (sel < 8) v = -int'($urandom_range(0, 99));
      else if (sel == 8) v = int'($urandom_range(990, 1100));
      else v = -int'($urandom_range(95, 130));
      sel = int'($urandom_range(0, 9));
      m = (sel < 4) ? 1 : (sel < 7) ? 0 : (sel < 9) ? 3 : 2;
      run_conv(v, m);
    end

    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule